// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller with Spurious Fallback

This block collects eight interrupt request lines and raises one interrupt output to the processor. Level 0 has the highest priority and level 7 the lowest. Each input is sensed either by its rising edge or by its level, selected by `edge_sel`. A mask input blocks chosen levels. An in-service register records the levels that are being handled, so that a request of equal or lower priority cannot interrupt them.

The processor answers `intr` with two acknowledge pulses on `ack`. The first pulse resolves priority, and the second pulse reads an 8-bit vector made of a 5-bit base and the level number. If no qualifying request is still present when the first pulse is seen, for example because a short edge pulse has already gone away, the block reports level 7. The vector and the cascade lines then look the same as for a real level-7 request, and no in-service bit is set. A secondary controller can be attached to any input flagged in `casc_en`. When such an input wins, the cascade lines carry its level number and this block leaves the vector undriven.

A pulse on `eoi` ends the service of the highest-priority level that is in service.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset `intr`, `vec_oe` and `cas_oe` are low and no level is in service.
- R2: `intr` is high when the highest-priority unmasked pending level has a lower index than every in-service level. Level 0 is the highest priority.
- R3: A level whose `mask` bit is 1 does not assert `intr` and cannot win priority. With `mask` equal to 8'hFF, `intr` stays low.
- R4: When `edge_sel`=1, a rising edge on an input latches a request. The request stays only while the input remains high. An input that stays high after its request was taken does not request again.
- R5: When `edge_sel`=0, a high input is a request for as long as it is high.
- R6: The block drives `vec` = {`vec_base`, level} with `vec_oe` high only while the second `ack` pulse is high. This begins the cycle after that pulse's rise is sampled.
- R7: At the first pulse, the winning level becomes in service and its edge latch is cleared. The level then blocks requests of its own and lower priority.
- R8: If no level qualifies when the first pulse is sampled, the block reports level 7 on `vec` and on `cas_id`, and it does not set the level-7 in-service bit.
- R9: When the reported level has its `casc_en` bit set, `cas_oe` is high and `cas_id` equals the level from the cycle after the first pulse until the sequence ends. During that time `vec_oe` stays low.
- R10: A one-cycle `eoi` pulse clears only the lowest-index in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 8 | Request lines, bit i is level i |
| edge_sel | input | 1 | 1 selects edge sensing, 0 selects level sensing |
| mask | input | 8 | 1 blocks the matching level |
| casc_en | input | 8 | 1 marks an input fed by a secondary controller |
| vec_base | input | 5 | Upper five bits of the vector |
| ack | input | 1 | Acknowledge pulses from the processor, active high |
| eoi | input | 1 | Non-specific end-of-interrupt pulse |
| intr | output | 1 | Interrupt request to the processor |
| vec | output | 8 | Vector byte |
| vec_oe | output | 1 | High when `vec` is driven |
| cas_id | output | 3 | Cascade identifier of the reported level |
| cas_oe | output | 1 | High when `cas_id` selects a secondary controller |

## Verification
On every cycle, the assertions check four things:
- the upper bits of a driven vector equal the base;
- a vector is driven only inside a high acknowledge pulse;
- the vector and the cascade lines are never active together;
- a fully masked input set never raises `intr`.

They also check that each end-of-interrupt removes exactly one in-service bit. Only the bench scenarios can show the rest:
- priority ordering against nested in-service levels;
- the loss of a short edge request;
- the level-7 fallback with no in-service side effect;
- the exact vector values, which a scoreboard compares in order.

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int NLVL = 8,
  parameter int BASEW = 5,
  localparam int LW = $clog2(NLVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLVL-1:0]  irq,
  input  logic             edge_sel,
  input  logic [NLVL-1:0]  mask,
  input  logic [NLVL-1:0]  casc_en,
  input  logic [BASEW-1:0] vec_base,
  input  logic             ack,
  input  logic             eoi,
  output logic             intr,
  output logic [BASEW+LW-1:0] vec,
  output logic             vec_oe,
  output logic [LW-1:0]    cas_id,
  output logic             cas_oe
);
  localparam logic [1:0] PH_IDLE = 2'd0, PH_ONE = 2'd1, PH_TWO = 2'd2;

  logic [NLVL-1:0] irq_q, edge_lat, isr;
  logic [1:0]      phase;
  logic            ack_q;
  logic [LW-1:0]   lvl;

  function automatic logic [LW:0] top_idx(input logic [NLVL-1:0] v);
    top_idx = (LW+1)'(NLVL);
    for (int i = NLVL-1; i >= 0; i--)
      if (v[i]) top_idx = (LW+1)'(i);
  endfunction

  wire [NLVL-1:0] irr  = edge_sel ? (edge_lat & irq) : irq;
  wire [NLVL-1:0] pend = irr & ~mask;
  wire [LW:0]     p    = top_idx(pend);
  wire [LW:0]     s    = top_idx(isr);
  wire            take = (p != (LW+1)'(NLVL)) && (p < s);
  wire            ack_rise = ack && !ack_q;
  wire            resolve  = ack_rise && (phase == PH_IDLE);
  wire [NLVL-1:0] isr_low  = isr & (~isr + 1'b1);
  wire [NLVL-1:0] grant    = (resolve && take) ? (NLVL'(1) << p[LW-1:0]) : '0;

  assign intr   = take;
  assign vec    = {vec_base, lvl};
  assign vec_oe = (phase == PH_TWO) && ack && !casc_en[lvl];
  assign cas_id = lvl;
  assign cas_oe = (phase != PH_IDLE) && casc_en[lvl];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= '0;
      edge_lat <= '0;
      isr      <= '0;
      phase    <= PH_IDLE;
      ack_q    <= 1'b0;
      lvl      <= '0;
    end else begin
      irq_q    <= irq;
      ack_q    <= ack;
      edge_lat <= ((edge_lat & irq) | (irq & ~irq_q)) & ~grant;
      isr      <= (eoi ? (isr & ~isr_low) : isr) | grant;
      case (phase)
        PH_IDLE: if (resolve) begin
          phase <= PH_ONE;
          lvl   <= take ? p[LW-1:0] : LW'(NLVL-1);
        end
        PH_ONE:  if (ack_rise) phase <= PH_TWO;
        default: if (!ack) phase <= PH_IDLE;
      endcase
    end
  end
endmodule

module irq_vec_ctrl_chk #(
  parameter int NLVL = 8,
  parameter int BASEW = 5,
  localparam int LW = $clog2(NLVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NLVL-1:0]  mask,
  input logic [BASEW-1:0] vec_base,
  input logic             ack,
  input logic             ack_q,
  input logic             eoi,
  input logic [1:0]       phase,
  input logic [NLVL-1:0]  isr,
  input logic             intr,
  input logic [BASEW+LW-1:0] vec,
  input logic             vec_oe,
  input logic             cas_oe
);
  a_r6_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> vec[BASEW+LW-1:LW] == vec_base);
  a_r6_vec_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> ack);
  a_r9_casc_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cas_oe |-> !vec_oe);
  a_r3_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !intr);
  a_r10_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr != '0 && !(ack && !ack_q && phase == 2'd0))
      |=> $countones(isr) == $past($countones(isr)) - 1);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NLVL(NLVL), .BASEW(BASEW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask(mask), .vec_base(vec_base), .ack(ack),
  .ack_q(ack_q), .eoi(eoi), .phase(phase), .isr(isr), .intr(intr),
  .vec(vec), .vec_oe(vec_oe), .cas_oe(cas_oe));

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] irq = 0, mask = 0, casc_en = 0;
  logic edge_sel = 0, ack = 0, eoi = 0;
  logic [4:0] vec_base = 5'h0B;
  logic intr, vec_oe, cas_oe;
  logic [7:0] vec;
  logic [2:0] cas_id;
  int checks = 0, errors = 0;
  logic [7:0] expq[$];
  logic vseen = 0;
  logic [2:0] cid;
  logic coe;

  always #10 clk = ~clk;

  irq_vec_ctrl dut (.clk(clk), .rst_n(rst_n), .irq(irq), .edge_sel(edge_sel),
    .mask(mask), .casc_en(casc_en), .vec_base(vec_base), .ack(ack), .eoi(eoi),
    .intr(intr), .vec(vec), .vec_oe(vec_oe), .cas_id(cas_id), .cas_oe(cas_oe));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (vec_oe && !vseen) begin
      vseen = 1;
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R6 actual=%0h expected=none", vec);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (vec !== e) begin
          errors++;
          $display("FAIL R6/R8 actual=%0h expected=%0h", vec, e);
        end
      end
    end
    if (!vec_oe) vseen = 0;
  end

  task automatic ack_seq(input int lvl_exp, input bit drives);
    if (drives) expq.push_back({vec_base, 3'(lvl_exp)});
    @(negedge clk) ack = 1;
    @(negedge clk);
    @(negedge clk) ack = 0;
    @(negedge clk);
    cid = cas_id; coe = cas_oe;
    ack = 1;
    @(negedge clk);
    @(negedge clk) ack = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_eoi();
    @(negedge clk) eoi = 1;
    @(negedge clk) eoi = 0;
  endtask

  task automatic setirq(input logic [7:0] v);
    @(negedge clk) irq = v;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!intr && !vec_oe && !cas_oe, "R1 reset outputs", {intr, vec_oe, cas_oe}, 0);

    setirq(8'h20);
    chk(intr, "R5 level request", intr, 1);
    ack_seq(5, 1);
    chk(!intr, "R7 in-service blocks same level", intr, 0);
    setirq(8'h00); pulse_eoi();

    setirq(8'h48);
    chk(intr, "R2 two pending", intr, 1);
    ack_seq(3, 1);
    chk(!intr, "R7 lower level blocked", intr, 0);
    setirq(8'h4A);
    chk(intr, "R2 higher level preempts", intr, 1);
    ack_seq(1, 1);
    setirq(8'h4C);
    chk(!intr, "R10 level 2 blocked by level 1", intr, 0);
    pulse_eoi(); @(negedge clk);
    chk(intr, "R10 eoi cleared level 1 only", intr, 1);
    ack_seq(2, 1);
    setirq(8'h00);
    repeat (3) pulse_eoi();

    mask = 8'h01;
    setirq(8'h01);
    chk(!intr, "R3 masked level", intr, 0);
    setirq(8'h03);
    chk(intr, "R3 unmasked level", intr, 1);
    ack_seq(1, 1);
    setirq(8'h00); pulse_eoi();
    mask = 8'hFF;
    setirq(8'hFF);
    chk(!intr, "R3 all masked", intr, 0);
    setirq(8'h00); mask = 8'h00;

    edge_sel = 1;
    setirq(8'h10);
    chk(intr, "R4 rising edge latched", intr, 1);
    ack_seq(4, 1);
    pulse_eoi(); @(negedge clk);
    chk(!intr, "R4 held high no new request", intr, 0);
    setirq(8'h00);
    setirq(8'h10);
    chk(intr, "R4 second edge", intr, 1);
    setirq(8'h00);
    chk(!intr, "R4 dropped request lost", intr, 0);
    ack_seq(7, 1);
    chk(!coe, "R8 spurious no cascade", coe, 0);
    setirq(8'h80);
    chk(intr, "R8 spurious left level 7 free", intr, 1);
    ack_seq(7, 1);
    setirq(8'h00); pulse_eoi();

    edge_sel = 0;
    casc_en = 8'h04;
    setirq(8'h04);
    ack_seq(2, 0);
    chk(coe && cid == 3'd2, "R9 cascade id level 2", {coe, cid}, 4'hA);
    chk(!cas_oe, "R9 cascade released", cas_oe, 0);
    setirq(8'h00); pulse_eoi();

    casc_en = 8'h80;
    ack_seq(7, 0);
    chk(coe && cid == 3'd7, "R8 spurious cascade id 7", {coe, cid}, 4'hF);
    casc_en = 8'h00;

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R6 all vectors seen", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule